// File: doc/BRIEF.md
# Up/Down Period Timer-Counter

This block is a programmable timer-counter that advances by one step on each enabled tick from a selectable clock divider. In the up direction it climbs to a programmed period value and then clears to zero. In the down direction it falls to zero and then reloads the period value. Each wrap sets a sticky overflow flag. Each wrap also produces a one-cycle overflow pulse, which other logic can use as an event or interrupt source.

Software reaches the block through a simple write port with eight addresses. Through this port it can:
- load the count value directly, even while the counter runs;
- set the period;
- set or clear the direction and one-shot controls;
- issue start and stop commands;
- pick the division ratio;
- clear the flag;
- enable the counter, and choose whether the input event stops it.

In one-shot mode the counter halts after its first wrap. A start command, or a write to the count, arms it again.

Top module: `updown_timer`

## Requirements
- R1: The divider select `wr_data[2:0]` at address 5 gives these tick ratios: code 0 → 1, code 1 → 2, code 2 → 4, code 3 → 8, code 4 → 64, code 5 → 256, code 6 → 1024, code 7 → 1024. The divider is held at its start while the counter is disabled. With ratio D, the k-th tick after the enabling edge lands on the (k·D)-th rising edge after it.
- R2: When counting up, a tick while the count equals the period loads zero. Any other tick adds one.
- R3: When counting down, a tick while the count is zero loads the period (address 1). Any other tick subtracts one.
- R4: Every wrap from R2 or R3 sets `ovf_flag_o`. The flag stays set until a write to address 6 with bit 0 = 1. A write to address 6 with bit 0 = 0 leaves it unchanged. If a wrap and a clear arrive together, the wrap wins.
- R5: `ovf_pulse_o` is high for exactly the one clock that follows each wrap edge, and it is low otherwise.
- R6: While one-shot is set (bit 1 at address 2 sets it, bit 1 at address 3 clears it), a wrap still clears or reloads the count and then halts counting. `run_o` drops to 0.
- R7: A write to address 0 loads `wr_data` into the count on that edge. It overrides any increment, decrement, clear or reload due on the same edge, and that edge produces no wrap.
- R8: Bit 0 at address 2 selects down-counting and bit 0 at address 3 selects up-counting. The direction may change while the counter runs. A tick on the edge of the change still uses the old direction.
- R9: A stop command (`wr_data[1:0]` = 2 at address 4) freezes the count starting with that edge. A high `evt_i` has the same effect, but only while configuration bit 1 at address 7 is set. While that bit is clear, `evt_i` is ignored.
- R10: A start command (`wr_data[1:0]` = 1 at address 4) clears both the stopped and the halted states. Counting resumes from the held value on the edge after the command. A count write also clears a one-shot halt.
- R11: While enable (bit 0 at address 7) is clear, the count holds its value. The last tick still counts on the edge that disables the counter.
- R12: After reset the count is 0, the flag and pulse are low, `run_o` is 1, the counter is disabled, the direction is up, and the period is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | WIDTH | Write data |
| evt_i | input | 1 | Input event, acts as stop when configured |
| count_o | output | WIDTH | Current count value |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_pulse_o | output | 1 | One-cycle overflow pulse |
| run_o | output | 1 | High when neither stopped nor one-shot halted |

## Verification
The bench sweeps every divider ratio, and every small period in both directions, cycle by cycle. A divider that is off by one, or that is not restarted on enable, shows up as a count that moves one cycle early or late. A swapped clear and reload would leave a down-counter at zero or wrap an up-counter past the period. The bench writes the count on the same edge as a pending wrap. A design that let the step win would show zero and raise the flag. Stop, event, direction-change and one-shot sequences check that a frozen or halted counter never moves, that an unconfigured event is ignored, and that a retrigger resumes without skipping a value.

// File: rtl/updown_timer_pkg.sv
package updown_timer_pkg;

  // Divider counter width: the largest ratio is 1024.
  localparam int DIV_W = 10;

  typedef enum logic [2:0] {
    A_COUNT  = 3'd0,
    A_PERIOD = 3'd1,
    A_SET    = 3'd2,
    A_CLEAR  = 3'd3,
    A_CMD    = 3'd4,
    A_PRESC  = 3'd5,
    A_FLAG   = 3'd6,
    A_CFG    = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2,
    CMD_RSVD  = 2'd3
  } cmd_e;

  // Terminal value of the divider (ratio minus one) for each select code.
  function automatic logic [DIV_W-1:0] presc_limit(input logic [2:0] sel);
    logic [DIV_W-1:0] lim;
    case (sel)
      3'd0:    lim = DIV_W'(0);
      3'd1:    lim = DIV_W'(1);
      3'd2:    lim = DIV_W'(3);
      3'd3:    lim = DIV_W'(7);
      3'd4:    lim = DIV_W'(63);
      3'd5:    lim = DIV_W'(255);
      default: lim = DIV_W'(1023);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import updown_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit  = presc_limit(sel_i);
  assign tick_o = en_i && (div_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (!en_i)   div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && sel_i != 3'd0) |=> (!tick_o || sel_i == 3'd0));

endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import updown_timer_pkg::*;
#(
  parameter int WIDTH = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] period_o,
  output logic             dir_down_o,
  output logic             oneshot_o,
  output logic [2:0]       sel_o,
  output logic             enable_o,
  output logic             evt_stop_en_o,
  output logic             cnt_wr_o,
  output logic             start_o,
  output logic             stop_cmd_o,
  output logic             flag_clr_o
);

  logic hit_set, hit_clr, hit_cmd;

  assign hit_set    = wr_en && (wr_addr == A_SET);
  assign hit_clr    = wr_en && (wr_addr == A_CLEAR);
  assign hit_cmd    = wr_en && (wr_addr == A_CMD);
  assign cnt_wr_o   = wr_en && (wr_addr == A_COUNT);
  assign start_o    = hit_cmd && (wr_data[1:0] == CMD_START);
  assign stop_cmd_o = hit_cmd && (wr_data[1:0] == CMD_STOP);
  assign flag_clr_o = wr_en && (wr_addr == A_FLAG) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_o      <= '1;
      dir_down_o    <= 1'b0;
      oneshot_o     <= 1'b0;
      sel_o         <= 3'd0;
      enable_o      <= 1'b0;
      evt_stop_en_o <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_PERIOD) period_o <= wr_data;
      if (hit_set && wr_data[0]) dir_down_o <= 1'b1;
      else if (hit_clr && wr_data[0]) dir_down_o <= 1'b0;
      if (hit_set && wr_data[1]) oneshot_o <= 1'b1;
      else if (hit_clr && wr_data[1]) oneshot_o <= 1'b0;
      if (wr_en && wr_addr == A_PRESC) sel_o <= wr_data[2:0];
      if (wr_en && wr_addr == A_CFG) begin
        enable_o      <= wr_data[0];
        evt_stop_en_o <= wr_data[1];
      end
    end
  end

  // R8
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_set && wr_data[0]) |=> dir_down_o);

endmodule

// File: rtl/updown_count_core.sv
module updown_count_core #(
  parameter int WIDTH = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic             dir_down_i,
  input  logic             oneshot_i,
  input  logic [WIDTH-1:0] period_i,
  input  logic             cnt_wr_i,
  input  logic [WIDTH-1:0] cnt_data_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [WIDTH-1:0] count_o,
  output logic             run_o,
  output logic             wrap_o
);

  logic [WIDTH-1:0] count_q;
  logic             stopped_q, halted_q;
  logic             step_en, at_match;

  function automatic logic boundary(input logic [WIDTH-1:0] cnt,
                                    input logic [WIDTH-1:0] per,
                                    input logic down);
    return down ? (cnt == '0) : (cnt == per);
  endfunction

  function automatic logic [WIDTH-1:0] advance(input logic [WIDTH-1:0] cnt,
                                               input logic [WIDTH-1:0] per,
                                               input logic down);
    logic [WIDTH-1:0] nxt;
    if (down) nxt = (cnt == '0) ? per : cnt - 1'b1;
    else      nxt = (cnt == per) ? '0 : cnt + 1'b1;
    return nxt;
  endfunction

  assign run_o    = !stopped_q && !halted_q;
  assign step_en  = enable_i && tick_i && run_o && !stop_i && !cnt_wr_i;
  assign at_match = boundary(count_q, period_i, dir_down_i);
  assign wrap_o   = step_en && at_match;
  assign count_o  = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (cnt_wr_i) count_q <= cnt_data_i;
    else if (step_en)  count_q <= advance(count_q, period_i, dir_down_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stopped_q <= 1'b0;
      halted_q  <= 1'b0;
    end else begin
      if (stop_i)       stopped_q <= 1'b1;
      else if (start_i) stopped_q <= 1'b0;
      if (start_i || cnt_wr_i)       halted_q <= 1'b0;
      else if (wrap_o && oneshot_i)  halted_q <= 1'b1;
    end
  end

  // R2
  up_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !dir_down_i) |=> (count_q == '0));

  // R3
  down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && dir_down_i) |=> (count_q == $past(period_i)));

  // R7
  write_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> (count_q == $past(cnt_data_i)));

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !cnt_wr_i) |=> $stable(count_q));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !cnt_wr_i && !start_i) |=> $stable(count_q));

endmodule

// File: rtl/ovf_tracker.sv
module ovf_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= wrap_i;
      if (wrap_i)     flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  // R5
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> flag_o);

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import updown_timer_pkg::*;
#(
  parameter int WIDTH = 16
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             evt_i,
  output logic [WIDTH-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             ovf_pulse_o,
  output logic             run_o
);

  logic [WIDTH-1:0] period;
  logic [2:0]       sel;
  logic dir_down, oneshot, enable, evt_stop_en;
  logic cnt_wr, start_cmd, stop_cmd, flag_clr;
  logic tick, stop_now, wrap;

  timer_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period_o(period), .dir_down_o(dir_down),
    .oneshot_o(oneshot), .sel_o(sel), .enable_o(enable),
    .evt_stop_en_o(evt_stop_en), .cnt_wr_o(cnt_wr), .start_o(start_cmd),
    .stop_cmd_o(stop_cmd), .flag_clr_o(flag_clr)
  );

  tick_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .sel_i(sel), .tick_o(tick)
  );

  assign stop_now = stop_cmd || (evt_i && evt_stop_en);

  updown_count_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .enable_i(enable),
    .dir_down_i(dir_down), .oneshot_i(oneshot), .period_i(period),
    .cnt_wr_i(cnt_wr), .cnt_data_i(wr_data), .start_i(start_cmd),
    .stop_i(stop_now), .count_o(count_o), .run_o(run_o), .wrap_o(wrap)
  );

  ovf_tracker u_ovf (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .clr_i(flag_clr),
    .flag_o(ovf_flag_o), .pulse_o(ovf_pulse_o)
  );

  // R11
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !cnt_wr) |=> $stable(count_o));

endmodule

// File: tb/updown_timer_test.sv
`timescale 1ns/1ps
module updown_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = 3'd0;
  logic [15:0] wr_data = 16'd0;
  logic        evt_i = 1'b0;
  logic [15:0] count_o;
  logic        ovf_flag_o, ovf_pulse_o, run_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  updown_timer #(.WIDTH(16)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .evt_i(evt_i), .count_o(count_o),
    .ovf_flag_o(ovf_flag_o), .ovf_pulse_o(ovf_pulse_o), .run_o(run_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data[15:0];
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  function automatic int ratio(input int sel);
    if (sel < 4) return 1 << sel;
    if (sel == 4) return 64;
    if (sel == 5) return 256;
    return 1024;
  endfunction

  task automatic setup(input int sel, input int per, input int down,
                       input int one, input int cnt);
    wr(7, 0);
    wr(5, sel);
    wr(1, per);
    wr(3, 3);
    wr(2, (one << 1) | down);
    wr(0, cnt);
    wr(6, 1);
    wr(4, 1);
  endtask

  // Cycle-by-cycle sweep: n ticks after enable, count follows modulo (P+1)
  task automatic sweep(input int sel, input int p, input int down, input int len);
    int d;
    d = ratio(sel);
    setup(sel, p, down, 0, down ? p : 0);
    wr(7, 1);
    for (int m = 1; m <= len; m++) begin
      int n, ec, ep, ef;
      @(posedge clk); #1;
      n  = m / d;
      ec = down ? (p - (n % (p + 1))) : (n % (p + 1));
      ep = ((m % d) == 0 && n > 0 && (n % (p + 1)) == 0) ? 1 : 0;
      ef = (n >= p + 1) ? 1 : 0;
      chk(down ? "R3 count" : "R2 count", count_o, ec);
      chk("R5 pulse", ovf_pulse_o, ep);
      chk("R4 flag", ovf_flag_o, ef);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL R12 watchdog got=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c;
    #7 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 count", count_o, 0);
    chk("R12 flag", ovf_flag_o, 0);
    chk("R12 pulse", ovf_pulse_o, 0);
    chk("R12 run", run_o, 1);

    // R1 every divider code, including the duplicate code 7
    for (int s = 0; s < 8; s++) sweep(s, 1, 0, (s == 7) ? 2048 : 3 * ratio(s));

    // R2 / R3 period sweeps in both directions
    for (int p = 0; p < 6; p++) sweep(0, p, 0, 2 * (p + 1) + 2);
    for (int p = 0; p < 6; p++) sweep(0, p, 1, 2 * (p + 1) + 2);
    sweep(2, 2, 1, 40);

    // R4 flag clear by bit 0 only
    sweep(0, 1, 0, 4);
    wr(7, 0);
    wr(6, 0);
    chk("R4 clear bit0=0 ignored", ovf_flag_o, 1);
    wr(6, 1);
    chk("R4 clear", ovf_flag_o, 0);

    // R11 disable holds, last tick counts on the disabling edge
    sweep(0, 9, 0, 3);
    wr(7, 0);
    chk("R11 disable edge", count_o, 4);
    edges(5);
    chk("R11 hold", count_o, 4);

    // R7 write beats a due wrap
    setup(0, 5, 0, 0, 0);
    wr(7, 1);
    edges(5);
    chk("R7 at top", count_o, 5);
    wr(0, 2);
    chk("R7 write value", count_o, 2);
    chk("R7 no pulse", ovf_pulse_o, 0);
    chk("R7 no flag", ovf_flag_o, 0);
    edges(1);
    chk("R7 resumes", count_o, 3);

    // R8 direction change while running
    setup(0, 9, 0, 0, 0);
    wr(7, 1);
    edges(3);
    chk("R8 up", count_o, 3);
    wr(2, 1);
    chk("R8 old dir on change edge", count_o, 4);
    edges(2);
    chk("R8 down", count_o, 2);
    wr(3, 1);
    chk("R8 back edge", count_o, 1);
    edges(1);
    chk("R8 up again", count_o, 2);

    // R9 event ignored unless configured, then stops
    setup(0, 200, 0, 0, 0);
    wr(7, 1);
    c = count_o;
    @(negedge clk); evt_i = 1'b1; @(posedge clk); #1; evt_i = 1'b0;
    chk("R9 event ignored", count_o, c + 1);
    chk("R9 run kept", run_o, 1);
    wr(7, 3);
    c = count_o;
    @(negedge clk); evt_i = 1'b1; @(posedge clk); #1; evt_i = 1'b0;
    chk("R9 event freeze", count_o, c);
    chk("R9 run low", run_o, 0);
    edges(3);
    chk("R9 event hold", count_o, c);
    wr(4, 1);
    chk("R10 start edge", count_o, c);
    edges(1);
    chk("R10 resume", count_o, c + 1);
    c = count_o;
    wr(4, 2);
    chk("R9 cmd freeze", count_o, c);
    edges(3);
    chk("R9 cmd hold", count_o, c);

    // R6 one-shot up, R10 retrigger and count-write re-arm
    setup(0, 3, 0, 1, 0);
    wr(7, 1);
    edges(4);
    chk("R6 wrapped", count_o, 0);
    edges(6);
    chk("R6 halted count", count_o, 0);
    chk("R6 run low", run_o, 0);
    chk("R6 flag", ovf_flag_o, 1);
    wr(4, 1);
    chk("R10 retrigger edge", count_o, 0);
    chk("R10 run", run_o, 1);
    edges(1);
    chk("R10 after retrigger", count_o, 1);
    edges(3);
    edges(3);
    chk("R6 halted again", count_o, 0);
    wr(0, 2);
    chk("R10 rearm write", count_o, 2);
    edges(1);
    chk("R10 rearm count", count_o, 3);

    // R6 one-shot down
    setup(0, 2, 1, 1, 2);
    wr(7, 1);
    edges(3);
    chk("R6 down reload", count_o, 2);
    edges(4);
    chk("R6 down halted", count_o, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule